// File: doc/BRIEF.md
# Registered Bidirectional Byte Transceiver

This block joins two byte-wide buses, A and B, through a path whose direction is chosen by a control input. Each direction owns a capture register. The A-side register is loaded from the A bus by its own capture clock, and the B-side register is loaded from the B bus by a second capture clock. Every capture edge loads data, whatever the output controls are doing. A bus can therefore be sampled while the block drives nothing at all.

For the bus being driven, a per-direction source select picks one of two sources. The first is the live value of the opposite bus, passed through combinationally. The second is the value held in that direction's register. An active-low output enable and the direction input decide which bus, if any, is driven. Each bidirectional bus is split into an input, an output and an output-enable port, so the block has no tri-state logic. A wider part is built by placing several of these lanes side by side, each with its own controls.

Reset is asynchronous and active low. Its release is synchronized separately inside each capture-clock domain, so each register stays cleared for two of its own clock edges after reset rises.

Top module: `xcvr_reg_byte`

## Requirements
- R1: While rst_n is low, both capture registers hold zero. Each register keeps ignoring its capture clock for the first two rising edges after rst_n rises and loads from the third edge on.
- R2: With oe_n high, a_oe and b_oe are both 0 and a_out and b_out are both 0. A bus that is not driven always shows 0 on its output.
- R3: On every rising edge of clk_ab, the A register loads a_in, whatever the values of oe_n, dir and the selects.
- R4: On every rising edge of clk_ba, the B register loads b_in, whatever the values of oe_n, dir and the selects.
- R5: With oe_n low, dir = 1 gives b_oe = 1 and a_oe = 0, and dir = 0 gives a_oe = 1 and b_oe = 0. The two enables are never 1 together.
- R6: With oe_n low, dir = 1 and sel_ab = 0, b_out equals a_in combinationally, with no clock edge needed.
- R7: With oe_n low, dir = 1 and sel_ab = 1, b_out equals the A register, and it changes only after a clk_ab edge.
- R8: With oe_n low, dir = 0 and sel_ba = 0, a_out equals b_in combinationally.
- R9: With oe_n low, dir = 0 and sel_ba = 1, a_out equals the B register, and it changes only after a clk_ba edge.
- R10: In stored mode, one capture edge both loads the register and presents the new value on the driven bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ab | input | 1 | Capture clock for the A register |
| clk_ba | input | 1 | Capture clock for the B register |
| oe_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| sel_ab | input | 1 | B-side source: 0 live A bus, 1 A register |
| sel_ba | input | 1 | A-side source: 0 live B bus, 1 B register |
| a_in | input | 8 | Value seen on the A bus |
| a_out | output | 8 | Value driven onto the A bus |
| a_oe | output | 1 | A bus is driven |
| b_in | input | 8 | Value seen on the B bus |
| b_out | output | 8 | Value driven onto the B bus |
| b_oe | output | 1 | B bus is driven |

## Verification
The directions are exercised with four kinds of pattern. Isolated cycles capture on both clocks together, and later reads of those values show whether storage is truly independent of the enables. Each direction is run first live and then stored while the opposite bus holds a different value, so a wrong source select gives a visibly different byte. Stored reads are made once without an edge and once with a capture edge, which separates a value that is held from one that is loaded and shown in the same step. A capture on the undriven side while the other side is driven shows that the two registers do not interfere.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drv_e;
endpackage

// File: rtl/xcvr_hold_reg.sv
// Capture register with per-domain synchronized reset release.
module xcvr_hold_reg #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             live
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0]      sync_q, sync_d;
  logic [WIDTH-1:0]   q_d;
  logic               cap_en;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[LAST-1:0], 1'b1};
    end
  endgenerate

  assign live   = sync_q[LAST];
  assign cap_en = live;

  always_comb begin
    q_d = q;
    if (cap_en) q_d = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      q      <= '0;
    end else begin
      sync_q <= sync_d;
      q      <= q_d;
    end
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
// Decides which bus, if any, is driven.
module xcvr_drive_ctl
  import xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir,
  output drv_e drv,
  output logic a_oe,
  output logic b_oe
);
  always_comb begin
    if (oe_n)     drv = DRV_NONE;
    else if (dir) drv = DRV_B;
    else          drv = DRV_A;
  end

  assign a_oe = (drv == DRV_A);
  assign b_oe = (drv == DRV_B);
endmodule

// File: rtl/xcvr_path_sel.sv
// Chooses live or stored source; forces zero when not driving.
module xcvr_path_sel #(
  parameter int WIDTH = 8
) (
  input  logic             en,
  input  logic             use_reg,
  input  logic [WIDTH-1:0] live_val,
  input  logic [WIDTH-1:0] reg_val,
  output logic [WIDTH-1:0] out
);
  always_comb begin
    out = '0;
    if (en) out = use_reg ? reg_val : live_val;
  end
endmodule

// File: rtl/xcvr_reg_byte.sv
module xcvr_reg_byte #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             rst_n,
  input  logic             clk_ab,
  input  logic             clk_ba,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  import xcvr_pkg::*;

  logic [WIDTH-1:0] q_ab, q_ba;
  logic             live_ab, live_ba;
  drv_e             drv;

  xcvr_hold_reg #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_reg_ab (
    .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(q_ab), .live(live_ab)
  );

  xcvr_hold_reg #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_reg_ba (
    .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(q_ba), .live(live_ba)
  );

  xcvr_drive_ctl u_ctl (
    .oe_n(oe_n), .dir(dir), .drv(drv), .a_oe(a_oe), .b_oe(b_oe)
  );

  xcvr_path_sel #(.WIDTH(WIDTH)) u_to_b (
    .en(drv == DRV_B), .use_reg(sel_ab), .live_val(a_in), .reg_val(q_ab), .out(b_out)
  );

  xcvr_path_sel #(.WIDTH(WIDTH)) u_to_a (
    .en(drv == DRV_A), .use_reg(sel_ba), .live_val(b_in), .reg_val(q_ba), .out(a_out)
  );
endmodule

// File: rtl/xcvr_reg_byte_chk.sv
module xcvr_reg_byte_chk #(
  parameter int WIDTH = 8
) (
  input logic             rst_n,
  input logic             clk_ab,
  input logic             clk_ba,
  input logic             oe_n,
  input logic             dir,
  input logic             sel_ab,
  input logic             sel_ba,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe,
  input logic [WIDTH-1:0] q_ab,
  input logic [WIDTH-1:0] q_ba,
  input logic             live_ab,
  input logic             live_ba
);
  assert_isolate_R2: assert property (@(posedge clk_ab) disable iff (!rst_n)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  assert_dir_map_R5: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !oe_n |-> (b_oe == dir && a_oe == !dir));

  assert_oe_excl_R5: assert property (@(posedge clk_ba) disable iff (!rst_n)
    !(a_oe && b_oe));

  assert_capture_a_R3: assert property (@(posedge clk_ab) disable iff (!rst_n)
    live_ab |=> q_ab == $past(a_in));

  assert_capture_b_R4: assert property (@(posedge clk_ba) disable iff (!rst_n)
    live_ba |=> q_ba == $past(b_in));

  assert_live_ab_R6: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_oe && !sel_ab) |-> b_out == a_in);

  assert_stored_ab_R7: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (b_oe && sel_ab) |-> b_out == q_ab);

  assert_live_ba_R8: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (a_oe && !sel_ba) |-> a_out == b_in);

  assert_stored_ba_R9: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (a_oe && sel_ba) |-> a_out == q_ba);
endmodule

bind xcvr_reg_byte xcvr_reg_byte_chk #(.WIDTH(WIDTH)) u_chk (
  .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .q_ab(q_ab), .q_ba(q_ba),
  .live_ab(live_ab), .live_ba(live_ba)
);

// File: tb/sim_xcvr_reg_byte.sv
module sim_xcvr_reg_byte;
  typedef struct packed {
    logic       oe_n, dir, sab, sba, pab, pba;
    logic [7:0] a, b;
    logic       x_aoe, x_boe;
    logic [7:0] x_aout, x_bout;
  } vec_t;

  localparam int NV = 12;
  // oe_n dir sab sba pab pba a b | aoe boe aout bout
  localparam vec_t VECS [NV] = '{
    '{1,1,0,0,1,1,8'h11,8'h22, 0,0,8'h00,8'h00}, // isolated, both capture
    '{0,1,0,0,0,0,8'h33,8'h44, 0,1,8'h00,8'h33}, // A->B live
    '{0,1,1,0,0,0,8'h33,8'h44, 0,1,8'h00,8'h11}, // A->B stored
    '{0,1,1,0,1,0,8'h5A,8'h44, 0,1,8'h00,8'h5A}, // capture+show
    '{0,1,1,0,0,0,8'h66,8'h44, 0,1,8'h00,8'h5A}, // stored holds
    '{0,0,0,0,0,0,8'h66,8'h77, 1,0,8'h77,8'h00}, // B->A live
    '{0,0,0,1,0,0,8'h66,8'h77, 1,0,8'h22,8'h00}, // B->A stored
    '{0,0,0,1,0,1,8'h66,8'h9C, 1,0,8'h9C,8'h00}, // capture+show
    '{0,0,0,1,1,0,8'hE1,8'h10, 1,0,8'h9C,8'h00}, // A capture while A driven
    '{0,1,1,1,0,0,8'h00,8'h10, 0,1,8'h00,8'hE1}, // read back A reg
    '{1,0,1,1,0,1,8'h00,8'hF0, 0,0,8'h00,8'h00}, // isolated B capture
    '{0,0,1,1,0,0,8'h00,8'h00, 1,0,8'hF0,8'h00}  // read back B reg
  };

  logic       clk = 0;
  logic       rst_n, clk_ab, clk_ba, oe_n, dir, sel_ab, sel_ba;
  logic [7:0] a_in, b_in, a_out, b_out;
  logic       a_oe, b_oe;
  int         checks = 0, errors = 0, cycles = 0;

  xcvr_reg_byte u0 (
    .rst_n(rst_n), .clk_ab(clk_ab), .clk_ba(clk_ba), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks = checks + 1;
    if (got !== exp) begin
      errors = errors + 1;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic pab, input logic pba);
    #2;
    clk_ab = pab;
    clk_ba = pba;
    #2;
    clk_ab = 0;
    clk_ba = 0;
    #2;
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2 R3 R4";
      1: return "R6 R5";
      2: return "R7";
      3: return "R10 R7";
      4: return "R7 hold";
      5: return "R8 R5";
      6: return "R9";
      7: return "R10 R9";
      8: return "R3 R9";
      9: return "R3 R7";
      10: return "R2 R4";
      default: return "R4 R9";
    endcase
  endfunction

  initial begin
    rst_n = 0; clk_ab = 0; clk_ba = 0; oe_n = 1; dir = 1;
    sel_ab = 1; sel_ba = 1; a_in = 8'hAA; b_in = 8'h55;
    #10;
    oe_n = 0;
    #1;
    chk("R1 reset B out", b_out, 8'h00);
    rst_n = 1;
    // first two edges after release must not load
    pulse(1, 1);
    pulse(1, 1);
    chk("R1 A reg after two edges", b_out, 8'h00);
    dir = 0;
    #1;
    chk("R1 B reg after two edges", a_out, 8'h00);
    chk("R5 a_oe", {7'd0, a_oe}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      oe_n = VECS[i].oe_n; dir = VECS[i].dir;
      sel_ab = VECS[i].sab; sel_ba = VECS[i].sba;
      a_in = VECS[i].a; b_in = VECS[i].b;
      pulse(VECS[i].pab, VECS[i].pba);
      chk(tag_of(i), {7'd0, a_oe}, {7'd0, VECS[i].x_aoe});
      chk(tag_of(i), {7'd0, b_oe}, {7'd0, VECS[i].x_boe});
      chk(tag_of(i), a_out, VECS[i].x_aout);
      chk(tag_of(i), b_out, VECS[i].x_bout);
    end

    // R6 / R8: live paths follow without any clock
    oe_n = 0; dir = 1; sel_ab = 0; a_in = 8'h3C;
    #1;
    chk("R6 live no edge", b_out, 8'h3C);
    dir = 0; sel_ba = 0; b_in = 8'hC3;
    #1;
    chk("R8 live no edge", a_out, 8'hC3);

    // R1: asynchronous reset clears the stored value at once
    sel_ba = 1;
    #1;
    chk("R9 before reset", a_out, 8'hF0);
    rst_n = 0;
    #1;
    chk("R1 async clear", a_out, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule